// File: doc/BRIEF.md
# Interrupt Status Register Bank

This block holds four 8-bit registers behind a small synchronous read/write port, selected by a 2-bit address. Address 0 is a read-only status word. It combines six sticky interrupt flags with two live line-level mirrors. Addresses 1, 2 and 3 are configuration registers: a C/Q line setup register, a DI/DO setup register and a mode register.

Event inputs report faults, undervoltage on two supplies, overtemperature and wake-up. While an input is high it sets its flag. A flag then stays set until the host reads the status word. The level output `irq` is high whenever any flag is set.

A read of address 0 returns the word as it stood before the read and clears the flags on that same clock edge. An event present in that cycle sets its flag again, so a condition that is still active cannot be lost. The wake-up flag is armed only by an enable bit in the mode register. A DO fault also marks a hardware-set bit in the mode register.

Top module: `irq_regbank`

## Requirements
- R1: After reset the six interrupt flags are 0, the registers at addresses 1, 2 and 3 read 0x00, and `irq` is 0.
- R2: The registers at addresses 1 (C/Q setup), 2 (DI/DO setup) and 3 (mode) read back the last value written. The exception is mode bit 5, which hardware sets (see R8).
- R3: A write to address 0 has no effect on the status word or on `irq`.
- R4: The status word is laid out, from bit 7 down to bit 0, as: wake-up flag, DO fault flag, DI level, Q level, C/Q fault flag, 3.3 V undervoltage flag, 24 V undervoltage flag, overtemperature flag. An event held high for one cycle sets its flag on the next clock edge, and the flag stays set after the event ends.
- R5: `rdata` follows `addr` combinationally. A cycle with `rd_en` high and `addr` = 0 returns the flags as they stood before the read, and clears all six flags at the end of that cycle.
- R6: An event that is high during a status read cycle leaves its flag set after the clear. This covers both a condition that is still held and an event that arrives in the same cycle as the read.
- R7: The wake-up flag (status bit 7) is set by `ev_wake` only while mode bit 6 is 1.
- R8: A DO fault event sets status bit 6 and mode bit 5 together. Mode bit 5 is not cleared by a status read. Only a write of 0 to that bit clears it, and only while no DO fault is present.
- R9: Status bit 5 equals the inverse of `di_logic`, and status bit 4 equals `q_line`. Both are live, are unaffected by status reads, and do not drive `irq`.
- R10: `irq` is 1 exactly when at least one of the six interrupt flags is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; clears the flags when `addr` is 0 |
| rdata | output | 8 | Read data for `addr` |
| ev_wake | input | 1 | Wake-up request detected |
| ev_do_fault | input | 1 | DO driver fault condition |
| ev_cq_fault | input | 1 | C/Q driver fault condition |
| ev_uv33 | input | 1 | 3.3 V undervoltage |
| ev_uv24 | input | 1 | 24 V undervoltage |
| ev_otemp | input | 1 | Overtemperature |
| di_logic | input | 1 | DI receiver logic output |
| q_line | input | 1 | Q line level |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest situation to reach from the ports is a status read that shares its cycle with an event. That is where the set-over-clear priority decides whether an event survives.

The bench produces it in two ways. In the first, it raises a fresh event on the same falling edge that starts the read. The read must then return the flag as 0, and the next read must return it as 1. In the second, it holds a fault condition across consecutive reads, and every read must show the flag set until the condition is gone.

// File: rtl/irq_regbank.sv
module irq_regbank #(
  parameter int AW = 2,
  parameter int DW = 8,
  parameter int WAKE_EN_BIT = 6,
  parameter int DO_FLT_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  input  logic          ev_wake,
  input  logic          ev_do_fault,
  input  logic          ev_cq_fault,
  input  logic          ev_uv33,
  input  logic          ev_uv24,
  input  logic          ev_otemp,
  input  logic          di_logic,
  input  logic          q_line,
  output logic          irq
);
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_CQ   = AW'(1);
  localparam logic [AW-1:0] A_DIO  = AW'(2);
  localparam logic [AW-1:0] A_MODE = AW'(3);

  logic [5:0]    int_q, int_set;
  logic [DW-1:0] cq_q, dio_q, mode_q, mode_nx, status;
  logic          clr;

  assign clr     = rd_en && addr == A_STAT;
  assign int_set = {ev_wake & mode_q[WAKE_EN_BIT], ev_do_fault, ev_cq_fault,
                    ev_uv33, ev_uv24, ev_otemp};
  assign status  = {int_q[5], int_q[4], ~di_logic, q_line, int_q[3:0]};
  assign irq     = |int_q;

  always_comb begin
    mode_nx = (wr_en && addr == A_MODE) ? wdata : mode_q;
    if (ev_do_fault) mode_nx[DO_FLT_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q  <= '0;
      cq_q   <= '0;
      dio_q  <= '0;
      mode_q <= '0;
    end else begin
      int_q  <= (clr ? 6'd0 : int_q) | int_set;
      mode_q <= mode_nx;
      if (wr_en && addr == A_CQ)  cq_q  <= wdata;
      if (wr_en && addr == A_DIO) dio_q <= wdata;
    end
  end

  always_comb begin
    case (addr)
      A_STAT:  rdata = status;
      A_CQ:    rdata = cq_q;
      A_DIO:   rdata = dio_q;
      default: rdata = mode_q;
    endcase
  end
endmodule

// File: rtl/irq_regbank_chk.sv
module irq_regbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic       ev_wake,
  input logic       ev_do_fault,
  input logic       ev_cq_fault,
  input logic       ev_uv33,
  input logic       ev_uv24,
  input logic       ev_otemp,
  input logic       wake_en,
  input logic       do_mode,
  input logic [5:0] flags,
  input logic       irq
);
  logic any_ev;
  assign any_ev = ev_wake | ev_do_fault | ev_cq_fault | ev_uv33 | ev_uv24 | ev_otemp;

  a_r4_otemp_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_otemp |=> flags[0]);
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0 && !any_ev) |=> !irq);
  a_r6_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0 && ev_cq_fault) |=> flags[3]);
  a_r3_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && !rd_en && !any_ev) |=> $stable(flags));
  a_r7_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags[5] && !(ev_wake && wake_en)) |=> !flags[5]);
  a_r8_do_pair: assert property (@(posedge clk) disable iff (!rst_n)
    ev_do_fault |=> (do_mode && flags[4]));
  a_r10_irq_follows_event: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_uv24 || ev_uv33) |=> irq);
endmodule

bind irq_regbank irq_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .ev_wake(ev_wake), .ev_do_fault(ev_do_fault), .ev_cq_fault(ev_cq_fault),
  .ev_uv33(ev_uv33), .ev_uv24(ev_uv24), .ev_otemp(ev_otemp),
  .wake_en(mode_q[6]), .do_mode(mode_q[5]), .flags(int_q), .irq(irq)
);

// File: tb/irq_regbank_bench.sv
module irq_regbank_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic       wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       ev_wake = 0, ev_do_fault = 0, ev_cq_fault = 0;
  logic       ev_uv33 = 0, ev_uv24 = 0, ev_otemp = 0;
  logic       di_logic = 1, q_line = 0;
  logic       irq;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_regbank u_irq_regbank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .ev_wake(ev_wake), .ev_do_fault(ev_do_fault),
    .ev_cq_fault(ev_cq_fault), .ev_uv33(ev_uv33), .ev_uv24(ev_uv24),
    .ev_otemp(ev_otemp), .di_logic(di_logic), .q_line(q_line), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pulse(ref logic ev);
    @(negedge clk); ev = 1;
    @(negedge clk); ev = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 irq", {7'd0, irq}, 8'h00);
    peek(2'd1, d); check("R1 cq cfg", d, 8'h00);
    peek(2'd2, d); check("R1 dio cfg", d, 8'h00);
    peek(2'd3, d); check("R1 mode", d, 8'h00);
    peek(2'd0, d); check("R1 flags", d & 8'hCF, 8'h00);
  endtask

  task automatic t_config;
    logic [7:0] d;
    wr(2'd1, 8'hA5); wr(2'd2, 8'h3C); wr(2'd3, 8'h81);
    peek(2'd1, d); check("R2 cq", d, 8'hA5);
    peek(2'd2, d); check("R2 dio", d, 8'h3C);
    peek(2'd3, d); check("R2 mode", d, 8'h81);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_stat_write;
    logic [7:0] d;
    wr(2'd0, 8'hFF);
    check("R3 irq", {7'd0, irq}, 8'h00);
    peek(2'd0, d); check("R3 flags", d & 8'hCF, 8'h00);
  endtask

  task automatic t_events;
    logic [7:0] d;
    pulse(ev_otemp);
    check("R10 irq set", {7'd0, irq}, 8'h01);
    rd(2'd0, d); check("R4 otemp bit0", d & 8'hCF, 8'h01);
    check("R5 irq cleared", {7'd0, irq}, 8'h00);
    rd(2'd0, d); check("R5 flags cleared", d & 8'hCF, 8'h00);
    pulse(ev_uv24); rd(2'd0, d); check("R4 uv24 bit1", d & 8'hCF, 8'h02);
    pulse(ev_uv33); rd(2'd0, d); check("R4 uv33 bit2", d & 8'hCF, 8'h04);
    pulse(ev_cq_fault); pulse(ev_uv24);
    rd(2'd0, d); check("R4 cq bit3 sticky", d & 8'hCF, 8'h0A);
    check("R10 irq low after read", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_hold;
    logic [7:0] d;
    @(negedge clk); ev_cq_fault = 1;
    rd(2'd0, d); check("R6 held read1", d & 8'hCF, 8'h08);
    rd(2'd0, d); check("R6 held read2", d & 8'hCF, 8'h08);
    ev_cq_fault = 0;
    rd(2'd0, d); check("R6 last set", d & 8'hCF, 8'h08);
    rd(2'd0, d); check("R6 released", d & 8'hCF, 8'h00);
  endtask

  task automatic t_coincide;
    logic [7:0] d;
    @(negedge clk); addr = 2'd0; rd_en = 1; ev_uv24 = 1; #1 d = rdata;
    check("R5 pre-clear value", d & 8'hCF, 8'h00);
    @(negedge clk); rd_en = 0; ev_uv24 = 0;
    check("R6 irq after same-cycle event", {7'd0, irq}, 8'h01);
    rd(2'd0, d); check("R6 event kept", d & 8'hCF, 8'h02);
  endtask

  task automatic t_wake;
    logic [7:0] d;
    pulse(ev_wake);
    check("R7 gated irq", {7'd0, irq}, 8'h00);
    peek(2'd0, d); check("R7 gated bit7", d & 8'h80, 8'h00);
    wr(2'd3, 8'h40); pulse(ev_wake);
    check("R7 enabled irq", {7'd0, irq}, 8'h01);
    rd(2'd0, d); check("R7 bit7", d & 8'hCF, 8'h80);
  endtask

  task automatic t_dofault;
    logic [7:0] d;
    pulse(ev_do_fault);
    peek(2'd3, d); check("R8 mode bit5", d, 8'h60);
    rd(2'd0, d); check("R8 status bit6", d & 8'hCF, 8'h40);
    peek(2'd3, d); check("R8 mode survives read", d, 8'h60);
    @(negedge clk); ev_do_fault = 1;
    wr(2'd3, 8'h40);
    peek(2'd3, d); check("R8 write blocked by fault", d, 8'h60);
    ev_do_fault = 0;
    wr(2'd3, 8'h40);
    peek(2'd3, d); check("R8 write clears", d, 8'h40);
    rd(2'd0, d);
  endtask

  task automatic t_live;
    logic [7:0] d;
    @(negedge clk); di_logic = 0; q_line = 1;
    peek(2'd0, d); check("R9 levels", d, 8'h30);
    check("R9 no irq", {7'd0, irq}, 8'h00);
    rd(2'd0, d); rd(2'd0, d); check("R9 read keeps levels", d, 8'h30);
    @(negedge clk); di_logic = 1; q_line = 0;
    peek(2'd0, d); check("R9 levels follow", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_config();
    t_stat_write();
    t_events();
    t_hold();
    t_coincide();
    t_wake();
    t_dofault();
    t_live();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule